// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver (one half)

This block connects two data buses, called side A and side B, through a pair of storage registers. One register samples side A and the other samples side B. Each direction of transfer carries one of two sources onto the opposite bus, chosen by a select input: the live value arriving on the source side, or the value held in that side's register. A direction drives its destination bus only while its output enable is active. The A-to-B enable is active high and the B-to-A enable is active low.

Each bus side is modelled as three vectors: an input vector that carries what other agents put on the bus, an output vector, and an output-enable vector. The capture clocks of a discrete part are modelled here as capture strobes that take effect on the rising edge of a single system clock. A register loads whatever value is present on its bus at that edge. When its own side is being driven by the opposite direction, that driven value is what it loads. This lets one strobe copy data from one bus into both registers. A full device uses two of these halves side by side, and the data width is a parameter.

Top module: `bus_xcvr_half`

## Requirements
- R1: A synchronous active-high reset clears both registers to zero. After reset, any direction that selects stored data drives zero.
- R2: `b_oe` is all ones when `oe_ab` is 1 and all zeros otherwise. `a_oe` is all ones when `oe_ba_n` is 0 and all zeros otherwise. The enable vectors are never partly set.
- R3: With `sel_ab` = 0, `b_out` equals `a_in` in the same cycle, with no register in the path. With `sel_ba` = 0, `a_out` equals `b_in` in the same way.
- R4: With `sel_ab` = 1, `b_out` equals the A register. With `sel_ba` = 1, `a_out` equals the B register. Both values come from flip-flops.
- R5: On a clock edge where `cap_ab` is 1, the A register loads the value on bus A, whatever the selects and enables are. Without the strobe, it holds its value.
- R6: On a clock edge where `cap_ba` is 1, the B register loads the value on bus B, whatever the selects and enables are. Without the strobe, it holds its value.
- R7: When side A is driven (`oe_ba_n` = 0), the value on bus A is `a_out`, not `a_in`. With `sel_ba` = 0, one edge with both strobes therefore stores `b_in` in both registers.
- R8: When side B is driven (`oe_ab` = 1), the value on bus B is `b_out`, not `b_in`. With `sel_ab` = 0, one edge with both strobes therefore stores `a_in` in both registers.
- R9: When both sides are driven with stored data and both strobes fire in the same cycle, each register loads the other register's value from before that edge. The two registers swap.
- R10: With both enables inactive (isolation), neither side drives. Both registers can load their own bus inputs on the same edge.
- R11: With `oe_ab` = 1, `oe_ba_n` = 0 and both selects at 1, both buses are driven at once: the A register goes to `b_out` and the B register goes to `a_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; captures take effect on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | W | Value other agents place on bus A |
| a_out | output | W | Value this block puts on bus A |
| a_oe | output | W | Drive enable for bus A, all ones or all zeros |
| b_in | input | W | Value other agents place on bus B |
| b_out | output | W | Value this block puts on bus B |
| b_oe | output | W | Drive enable for bus B, all ones or all zeros |
| oe_ab | input | 1 | A-to-B output enable, active high |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| sel_ab | input | 1 | Source for bus B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for bus A: 0 live B, 1 stored B |
| cap_ab | input | 1 | Strobe: load bus A into the A register |
| cap_ba | input | 1 | Strobe: load bus B into the B register |

## Verification
The assertions check several things on every cycle. Each enable vector is always uniform. A strobe loads the undriven bus input, or the opposite direction's driven value when that side is being driven. A register holds its value when no strobe arrives. A simultaneous stored-to-stored capture swaps the registers. Only the bench scenarios can show the other behaviours: the reset value seen through the stored path, the same-cycle pass-through of live data, the copy of one bus into both registers from each side, and the complete picture of each function-table row, all compared against a model written from the requirements.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

    // Which source a direction forwards to the far bus.
    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    // Per-direction control after enable-polarity decode.
    typedef struct packed {
        logic     drive;  // far side is driven by this direction
        src_sel_e src;    // live or stored data
        logic     cap;    // capture strobe for the home-side register
    } dir_ctrl_t;

    localparam int unsigned NUM_DIRS = 2;

    // Turns an enable pin level into a "drive" flag, given its polarity.
    function automatic logic enable_active(input logic level, input logic act_low);
        return act_low ? ~level : level;
    endfunction

endpackage

// File: rtl/bus_xcvr_store_reg.sv
module bus_xcvr_store_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R5/R6: no strobe, no change
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/bus_xcvr_lane.sv
// One transfer direction: the register of its home side plus the source mux
// that feeds the far side.
module bus_xcvr_lane
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  dir_ctrl_t    ctrl,
    input  logic [W-1:0] home_in,      // external value on the home bus
    input  logic         home_drv,     // home bus driven by the opposite lane
    input  logic [W-1:0] home_drv_val, // value the opposite lane drives
    output logic [W-1:0] q,
    output logic [W-1:0] far_out,
    output logic [W-1:0] far_oe
);

    logic [W-1:0] home_bus;

    // What is physically present on the home bus this cycle.
    always_comb begin
        home_bus = home_drv ? home_drv_val : home_in;
    end

    bus_xcvr_store_reg #(.W(W)) u_reg (
        .clk  (clk),
        .rst  (rst),
        .load (ctrl.cap),
        .d    (home_bus),
        .q    (q)
    );

    always_comb begin
        unique case (ctrl.src)
            SRC_LIVE:   far_out = home_in;
            SRC_STORED: far_out = q;
            default:    far_out = home_in;
        endcase
        far_oe = {W{ctrl.drive}};
    end

    assert_cap_undriven_R5: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cap && !home_drv) |=> (q == $past(home_in)));

    assert_cap_driven_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl.cap && home_drv) |=> (q == $past(home_drv_val)));

    assert_oe_uniform_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(far_oe) == 0) || ($countones(far_oe) == W));

endmodule

// File: rtl/bus_xcvr_half.sv
module bus_xcvr_half
    import bus_xcvr_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic [W-1:0] b_oe,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic         cap_ab,
    input  logic         cap_ba
);

    // Index 0: side A (lane A->B), index 1: side B (lane B->A).
    dir_ctrl_t    ctrl    [NUM_DIRS];
    logic [W-1:0] side_in [NUM_DIRS];
    logic [W-1:0] lane_q  [NUM_DIRS];
    logic [W-1:0] lane_out[NUM_DIRS];
    logic [W-1:0] lane_oe [NUM_DIRS];

    always_comb begin
        ctrl[0] = '{drive: enable_active(oe_ab, 1'b0),
                    src:   src_sel_e'(sel_ab),
                    cap:   cap_ab};
        ctrl[1] = '{drive: enable_active(oe_ba_n, 1'b1),
                    src:   src_sel_e'(sel_ba),
                    cap:   cap_ba};
        side_in[0] = a_in;
        side_in[1] = b_in;
    end

    for (genvar g = 0; g < NUM_DIRS; g++) begin : g_lane
        localparam int unsigned OPP = NUM_DIRS - 1 - g;
        bus_xcvr_lane #(.W(W)) u_lane (
            .clk          (clk),
            .rst          (rst),
            .ctrl         (ctrl[g]),
            .home_in      (side_in[g]),
            .home_drv     (ctrl[OPP].drive),
            .home_drv_val (lane_out[OPP]),
            .q            (lane_q[g]),
            .far_out      (lane_out[g]),
            .far_oe       (lane_oe[g])
        );
    end

    // Lane A->B drives side B; lane B->A drives side A.
    assign b_out = lane_out[0];
    assign b_oe  = lane_oe[0];
    assign a_out = lane_out[1];
    assign a_oe  = lane_oe[1];

    assert_swap_R9: assert property (@(posedge clk) disable iff (rst)
        (cap_ab && cap_ba && oe_ab && !oe_ba_n && sel_ab && sel_ba)
        |=> ((lane_q[0] == $past(lane_q[1])) && (lane_q[1] == $past(lane_q[0]))));

    assert_isolation_R10: assert property (@(posedge clk) disable iff (rst)
        (!oe_ab && oe_ba_n) |-> ((a_oe == '0) && (b_oe == '0)));

endmodule

// File: tb/sim_bus_xcvr_half.sv
module sim_bus_xcvr_half;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic [W-1:0] a_out, a_oe, b_out, b_oe;
    logic         oe_ab, oe_ba_n, sel_ab, sel_ba, cap_ab, cap_ba;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [W-1:0] m_a, m_b;   // reference register contents

    always #2 clk = ~clk;     // 4 ns period

    bus_xcvr_half #(.W(W)) u0 (
        .clk(clk), .rst(rst),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .cap_ab(cap_ab), .cap_ba(cap_ba)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply static inputs just after a falling edge.
    task automatic setup(input logic oab, input logic obn, input logic sab, input logic sba,
                         input logic [W-1:0] av, input logic [W-1:0] bv);
        @(negedge clk);
        oe_ab = oab; oe_ba_n = obn; sel_ab = sab; sel_ba = sba;
        a_in = av; b_in = bv; cap_ab = 1'b0; cap_ba = 1'b0;
        #1;
    endtask

    // Compare every output against the model (R2, R3, R4).
    task automatic check_outputs(input string tag);
        chk({tag, " R2 a_oe"}, a_oe, {W{~oe_ba_n}});
        chk({tag, " R2 b_oe"}, b_oe, {W{oe_ab}});
        if (oe_ab)    chk({tag, " R3/R4 b_out"}, b_out, sel_ab ? m_a : a_in);
        if (!oe_ba_n) chk({tag, " R3/R4 a_out"}, a_out, sel_ba ? m_b : b_in);
    endtask

    // Fire strobes for one edge; the model applies the capture rules (R5-R9).
    task automatic strobe(input logic ca, input logic cb);
        logic [W-1:0] bus_a, bus_b;
        @(negedge clk);
        cap_ab = ca; cap_ba = cb;
        bus_a = (!oe_ba_n) ? (sel_ba ? m_b : b_in) : a_in;
        bus_b = oe_ab      ? (sel_ab ? m_a : a_in) : b_in;
        @(posedge clk);
        if (ca) m_a = bus_a;
        if (cb) m_b = bus_b;
        @(negedge clk);
        cap_ab = 1'b0; cap_ba = 1'b0;
        #1;
    endtask

    // Expose both registers through the stored paths.
    task automatic peek(input string tag);
        setup(1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00);
        chk({tag, " regA via b_out"}, b_out, m_a);
        chk({tag, " regB via a_out"}, a_out, m_b);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        setup(1'b1, 1'b0, 1'b1, 1'b1, 8'h5A, 8'hC3);
        cap_ab = 1'b1; cap_ba = 1'b1;   // strobes during reset lose to reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; cap_ab = 1'b0; cap_ba = 1'b0;
        m_a = '0; m_b = '0;
        #1;
        chk("R1 regA after reset", b_out, 8'h00);
        chk("R1 regB after reset", a_out, 8'h00);
    endtask

    task automatic t_isolation;
        setup(1'b0, 1'b1, 1'b1, 1'b0, 8'h3C, 8'hA5);
        check_outputs("R10 isolation");
        strobe(1'b1, 1'b1);
        check_outputs("R10 isolation after capture");
        peek("R10 R5 R6 isolation load");
    endtask

    task automatic t_live;
        setup(1'b1, 1'b1, 1'b0, 1'b0, 8'h81, 8'h7E);
        check_outputs("R3 live A to B");
        chk("R3 live A to B", b_out, 8'h81);
        a_in = 8'h18; #1;
        chk("R3 live A to B same cycle", b_out, 8'h18);
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h44, 8'hE7);
        check_outputs("R3 live B to A");
        chk("R3 live B to A", a_out, 8'hE7);
    endtask

    task automatic t_stored;
        setup(1'b1, 1'b1, 1'b1, 1'b0, 8'h99, 8'h11);
        check_outputs("R4 stored A to B");
        chk("R4 stored A to B", b_out, m_a);
        setup(1'b0, 1'b0, 1'b0, 1'b1, 8'h99, 8'h11);
        check_outputs("R4 stored B to A");
        chk("R4 stored B to A", a_out, m_b);
    endtask

    task automatic t_capture_ignores_controls;
        // B driven with stored A, strobe A only: A loads a_in (R5); B holds (R6).
        setup(1'b1, 1'b1, 1'b1, 1'b1, 8'h6D, 8'h00);
        strobe(1'b1, 1'b0);
        peek("R5 capture with stored select");
        // No strobes: both hold even with new inputs.
        setup(1'b0, 1'b1, 1'b0, 1'b0, 8'hFF, 8'hFF);
        repeat (3) @(posedge clk);
        peek("R5 R6 hold without strobe");
        // Strobe B only while B undriven.
        setup(1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 8'h2B);
        strobe(1'b0, 1'b1);
        peek("R6 capture B with A driven");
    endtask

    task automatic t_both_from_a;
        setup(1'b1, 1'b1, 1'b0, 1'b0, 8'hD4, 8'h0F);
        strobe(1'b1, 1'b1);
        peek("R8 store A into both");
        chk("R8 regB holds A data", m_b, 8'hD4);
    endtask

    task automatic t_both_from_b;
        setup(1'b0, 1'b0, 1'b0, 1'b0, 8'h1E, 8'hB2);
        strobe(1'b1, 1'b1);
        peek("R7 store B into both");
        chk("R7 regA holds B data", m_a, 8'hB2);
    endtask

    task automatic t_dual_stored_and_swap;
        setup(1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hA5);
        strobe(1'b1, 1'b1);
        setup(1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00);
        check_outputs("R11 both stored");
        chk("R11 b_out", b_out, 8'h3C);
        chk("R11 a_out", a_out, 8'hA5);
        strobe(1'b1, 1'b1);
        chk("R9 swap regA", b_out, 8'hA5);
        chk("R9 swap regB", a_out, 8'h3C);
    endtask

    initial begin
        #800000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; oe_ab = 1'b0; oe_ba_n = 1'b1; sel_ab = 1'b0; sel_ba = 1'b0;
        cap_ab = 1'b0; cap_ba = 1'b0; a_in = '0; b_in = '0;
        m_a = '0; m_b = '0;
        t_reset();
        t_isolation();
        t_live();
        t_stored();
        t_capture_ignores_controls();
        t_both_from_a();
        t_both_from_b();
        t_dual_stored_and_swap();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule